// File: doc/BRIEF.md
# Chained-Link Trigger Primitive Relay

This block is one node of a chain of readout boards that pass trigger primitives along a single link. From the upstream receiver it takes a stream of 16-bit words, each with a valid strobe. It rebuilds 64-bit primitives from every four valid words and queues each complete primitive in a FIFO. Toward the downstream transmitter it drives a 16-bit bus with its own valid strobe. It sends each primitive as one unbroken group of four words.

The node can also insert a primitive it produced itself. A one-entry holding register keeps that local primitive until the output reaches a primitive boundary with no forwarded traffic waiting. Forwarded and local words are never interleaved.

A parameter sets a minimum number of idle cycles between two primitives on the output. This lets the downstream link run slower than the input, so the queue can fill. When the FIFO is full, incoming primitives are dropped and a sticky flag records the loss. A second sticky flag records local primitives that were lost because the holding register was occupied.

Top module: `prim_relay_node`

## Requirements
- R1: A primitive is packed most significant word first. The first valid input word becomes bits 63:48, the fourth becomes bits 15:0, and the output sends bits 63:48 first and bits 15:0 last.
- R2: A primitive is committed only after four valid input words in consecutive cycles. If `in_valid` drops before the fourth word, the words already collected are discarded, and the next valid word starts a new primitive.
- R3: Each primitive leaves as `out_valid` high for exactly four consecutive cycles. Between two primitives there are at least `OUT_GAP` cycles with `out_valid` low.
- R4: `out_data` is all zeros in every cycle in which `out_valid` is low.
- R5: Forwarded primitives leave in the order in which they were completed at the input.
- R6: At a primitive boundary, a queued forwarded primitive is sent before a primitive in the local holding register.
- R7: A local primitive presented with `loc_valid` while the holding register is free is sent intact. If the output is idle and the FIFO is empty, its first word appears on the second rising edge after the edge that samples `loc_valid`.
- R8: A completed primitive that finds the FIFO full is dropped, and `fifo_ovf` is set and stays set until reset.
- R9: A local primitive presented while the holding register is occupied, and not being emptied in that cycle, is dropped. `loc_ovf` is set and stays set until reset.
- R10: A synchronous active-high `rst` clears the FIFO, the partial word count, the holding register, the output and both flags. No primitive held before reset is sent afterwards.
- R11: On an idle output with an empty FIFO, the first word of a forwarded primitive appears on the third rising edge after the edge that samples its fourth input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | WORD_W | Upstream word |
| loc_valid | input | 1 | Local primitive present (one cycle) |
| loc_prim | input | WORD_W*WORDS_PER_PRIM | Local primitive |
| out_valid | output | 1 | Downstream word valid |
| out_data | output | WORD_W | Downstream word, zero when idle |
| fifo_ovf | output | 1 | Sticky: forwarded primitive dropped |
| loc_ovf | output | 1 | Sticky: local primitive dropped |

## Verification
The bench builds the node with `FIFO_DEPTH` = 2 and `OUT_GAP` = 2. Each primitive then occupies the output for six cycles but arrives every four. A back-to-back input stream therefore fills the two-entry queue within a handful of primitives, which makes the drop path and `fifo_ovf` reachable. The same gap keeps forwarded traffic queued long enough that a held local primitive must wait behind it. This exercises both the priority rule at the boundary and the rejection of a second local primitive.

// File: rtl/prim_relay_pkg.sv
package prim_relay_pkg;

    // Output sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prim_relay_packer.sv
// Collects WORDS consecutive valid words into one primitive, first word on top.
module prim_relay_packer #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WORD_W-1:0]         in_word,
    output logic                      prim_push,
    output logic [WORD_W*WORDS-1:0]   prim_data
);
    import prim_relay_pkg::*;

    localparam int unsigned PRIM_W = WORD_W * WORDS;
    localparam int unsigned CNT_W  = cnt_width(WORDS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORDS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PRIM_W-1:0] acc;
        logic              push;
    } pack_t;

    pack_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        if (in_valid) begin
            r_d.acc = {r_q.acc[PRIM_W-WORD_W-1:0], in_word};
            if (r_q.cnt == LAST_IDX) begin
                r_d.push = 1'b1;
                r_d.cnt  = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            // a gap inside a primitive throws away the partial count
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign prim_push = r_q.push;
    assign prim_data = r_q.acc;

endmodule

// File: rtl/prim_relay_fifo.sv
// Whole-primitive queue with first-word fall-through head; push when full is dropped.
module prim_relay_fifo #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              drop
);
    import prim_relay_pkg::*;

    localparam int unsigned PTR_W = cnt_width(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic accept, take;

    always_comb begin
        p_d    = p_q;
        accept = push && (p_q.cnt != CNT_FULL);
        take   = pop && (p_q.cnt != '0);
        drop   = push && !accept;
        if (accept) p_d.wr = (p_q.wr == PTR_LAST) ? '0 : p_q.wr + 1'b1;
        if (take)   p_d.rd = (p_q.rd == PTR_LAST) ? '0 : p_q.rd + 1'b1;
        if (accept && !take)      p_d.cnt = p_q.cnt + 1'b1;
        else if (take && !accept) p_d.cnt = p_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[p_q.wr] <= push_data;
    end

    assign head      = mem[p_q.rd];
    assign not_empty = (p_q.cnt != '0);

endmodule

// File: rtl/prim_relay_holdreg.sv
// One-entry store for a locally produced primitive.
module prim_relay_holdreg #(
    parameter int unsigned PRIM_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_valid,
    input  logic [PRIM_W-1:0] loc_prim,
    input  logic              take,
    output logic              avail,
    output logic [PRIM_W-1:0] prim,
    output logic              drop
);
    typedef struct packed {
        logic              vld;
        logic [PRIM_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;
    logic  room;

    always_comb begin
        h_d  = h_q;
        room = !h_q.vld || take;
        drop = loc_valid && !room;
        if (take) h_d.vld = 1'b0;
        if (loc_valid && room) begin
            h_d.vld  = 1'b1;
            h_d.data = loc_prim;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign avail = h_q.vld;
    assign prim  = h_q.data;

endmodule

// File: rtl/prim_relay_sequencer.sv
// Sends primitives word by word, picks the next source at boundaries only.
module prim_relay_sequencer #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned GAP    = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fwd_avail,
    input  logic [WORD_W*WORDS-1:0] fwd_prim,
    input  logic                    loc_avail,
    input  logic [WORD_W*WORDS-1:0] loc_prim,
    output logic                    fwd_take,
    output logic                    loc_take,
    output logic                    out_valid,
    output logic [WORD_W-1:0]       out_word
);
    import prim_relay_pkg::*;

    localparam int unsigned PRIM_W = WORD_W * WORDS;
    localparam int unsigned IDX_W  = cnt_width(WORDS);
    localparam int unsigned G_W    = cnt_width(GAP);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);
    localparam logic [G_W-1:0]   GAP_LAST = G_W'((GAP > 0) ? GAP - 1 : 0);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [G_W-1:0]    gcnt;
        logic [PRIM_W-1:0] sh;
        logic              vld;
        logic [WORD_W-1:0] word;
    } seq_t;

    seq_t s_d, s_q;
    logic boundary;

    always_comb begin
        s_d      = s_q;
        fwd_take = 1'b0;
        loc_take = 1'b0;
        boundary = 1'b0;

        unique case (s_q.st)
            SEQ_SEND: begin
                s_d.sh  = {s_q.sh[PRIM_W-WORD_W-1:0], {WORD_W{1'b0}}};
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == IDX_LAST) begin
                    s_d.idx = '0;
                    if (GAP > 0) begin
                        s_d.st   = SEQ_GAP;
                        s_d.gcnt = '0;
                    end else begin
                        s_d.st   = SEQ_IDLE;
                        boundary = 1'b1;
                    end
                end
            end
            SEQ_GAP: begin
                s_d.gcnt = s_q.gcnt + 1'b1;
                if (s_q.gcnt == GAP_LAST) begin
                    s_d.st   = SEQ_IDLE;
                    boundary = 1'b1;
                end
            end
            default: boundary = 1'b1;
        endcase

        // forwarded traffic wins the boundary
        if (boundary && fwd_avail) begin
            fwd_take = 1'b1;
            s_d.st   = SEQ_SEND;
            s_d.idx  = '0;
            s_d.sh   = fwd_prim;
        end else if (boundary && loc_avail) begin
            loc_take = 1'b1;
            s_d.st   = SEQ_SEND;
            s_d.idx  = '0;
            s_d.sh   = loc_prim;
        end

        s_d.vld  = (s_d.st == SEQ_SEND);
        s_d.word = (s_d.st == SEQ_SEND) ? s_d.sh[PRIM_W-1 -: WORD_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_word  = s_q.word;

endmodule

// File: rtl/prim_relay_node.sv
// One chain node: rebuild, queue, merge with local, forward.
module prim_relay_node #(
    parameter int unsigned WORD_W         = 16,
    parameter int unsigned WORDS_PER_PRIM = 4,
    parameter int unsigned FIFO_DEPTH     = 4,
    parameter int unsigned OUT_GAP        = 0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic [WORD_W-1:0]                in_data,
    input  logic                             loc_valid,
    input  logic [WORD_W*WORDS_PER_PRIM-1:0] loc_prim,
    output logic                             out_valid,
    output logic [WORD_W-1:0]                out_data,
    output logic                             fifo_ovf,
    output logic                             loc_ovf
);
    localparam int unsigned PRIM_W = WORD_W * WORDS_PER_PRIM;

    typedef struct packed {
        logic fifo_ovf;
        logic loc_ovf;
    } flag_t;

    flag_t f_d, f_q;

    logic              pk_push;
    logic [PRIM_W-1:0] pk_data;
    logic [PRIM_W-1:0] q_head;
    logic              q_avail, q_drop, q_pop;
    logic [PRIM_W-1:0] h_prim;
    logic              h_avail, h_drop, h_take;

    prim_relay_packer #(.WORD_W(WORD_W), .WORDS(WORDS_PER_PRIM)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_data),
        .prim_push (pk_push),
        .prim_data (pk_data)
    );

    prim_relay_fifo #(.DATA_W(PRIM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (pk_push),
        .push_data (pk_data),
        .pop       (q_pop),
        .head      (q_head),
        .not_empty (q_avail),
        .drop      (q_drop)
    );

    prim_relay_holdreg #(.PRIM_W(PRIM_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .loc_valid (loc_valid),
        .loc_prim  (loc_prim),
        .take      (h_take),
        .avail     (h_avail),
        .prim      (h_prim),
        .drop      (h_drop)
    );

    prim_relay_sequencer #(.WORD_W(WORD_W), .WORDS(WORDS_PER_PRIM), .GAP(OUT_GAP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fwd_avail (q_avail),
        .fwd_prim  (q_head),
        .loc_avail (h_avail),
        .loc_prim  (h_prim),
        .fwd_take  (q_pop),
        .loc_take  (h_take),
        .out_valid (out_valid),
        .out_word  (out_data)
    );

    always_comb begin
        f_d          = f_q;
        f_d.fifo_ovf = f_q.fifo_ovf | q_drop;
        f_d.loc_ovf  = f_q.loc_ovf  | h_drop;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign fifo_ovf = f_q.fifo_ovf;
    assign loc_ovf  = f_q.loc_ovf;

endmodule

// File: rtl/prim_relay_chk.sv
// Port-level temporal checks, bound into every node instance.
module prim_relay_chk #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned WORDS  = 4,
    parameter int unsigned GAP    = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              fifo_ovf,
    input logic              loc_ovf
);
    int unsigned run_q;
    int unsigned idle_q;
    logic        prev_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 0;
            idle_q   <= GAP;
            prev_v_q <= 1'b0;
        end else begin
            prev_v_q <= out_valid;
            if (out_valid) begin
                run_q  <= (run_q == WORDS - 1) ? 0 : run_q + 1;
                idle_q <= 0;
            end else if (idle_q < GAP) begin
                idle_q <= idle_q + 1;
            end
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));                              // R4

    AST_WHOLE_RUN: assert property (@(posedge clk) disable iff (rst)
        (prev_v_q && !out_valid) |-> (run_q == 0));                    // R3

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        (!prev_v_q && out_valid) |-> (idle_q >= GAP));                 // R3

    AST_FIFO_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        fifo_ovf |=> fifo_ovf);                                        // R8

    AST_LOC_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        loc_ovf |=> loc_ovf);                                          // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !fifo_ovf && !loc_ovf));                // R10

endmodule

bind prim_relay_node prim_relay_chk #(
    .WORD_W (WORD_W),
    .WORDS  (WORDS_PER_PRIM),
    .GAP    (OUT_GAP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_data  (out_data),
    .fifo_ovf  (fifo_ovf),
    .loc_ovf   (loc_ovf)
);

// File: tb/sim_prim_relay_node.sv
`timescale 1ns/1ps
module sim_prim_relay_node;
    localparam int W     = 16;
    localparam int N     = 4;
    localparam int DEPTH = 2;
    localparam int GAP   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          loc_valid = 1'b0;
    logic [63:0]   loc_prim = '0;
    logic          out_valid;
    logic [W-1:0]  out_data;
    logic          fifo_ovf, loc_ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [63:0] got[$];
    int          got_cyc[$];
    int          got_gap[$];
    logic [63:0] cur;
    int          wcnt = 0;
    int          vrun = 0;
    int          idle = 0;
    int          idle_bad = 0;
    int          run_bad = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prim_relay_node #(
        .WORD_W(W), .WORDS_PER_PRIM(N), .FIFO_DEPTH(DEPTH), .OUT_GAP(GAP)
    ) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .loc_valid(loc_valid), .loc_prim(loc_prim),
        .out_valid(out_valid), .out_data(out_data),
        .fifo_ovf(fifo_ovf), .loc_ovf(loc_ovf)
    );

    // output monitor, sampled half a period after the edge
    always @(negedge clk) begin
        if (rst) begin
            wcnt = 0; vrun = 0; idle = 100;
        end else if (out_valid) begin
            if (wcnt == 0) begin
                got_cyc.push_back(cyc);
                got_gap.push_back(idle);
            end
            cur = {cur[47:0], out_data};
            wcnt++;
            vrun++;
            idle = 0;
            if (wcnt == N) begin
                got.push_back(cur);
                wcnt = 0;
            end
        end else begin
            if (out_data != '0) idle_bad++;
            if (vrun != 0 && vrun != N) run_bad++;
            vrun = 0;
            idle++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_prim(input logic [63:0] p);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = p[63 - 16*i -: 16];
        end
    endtask

    task automatic in_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic put_local(input logic [63:0] p);
        @(negedge clk);
        loc_valid = 1'b1;
        loc_prim  = p;
        @(negedge clk);
        loc_valid = 1'b0;
        loc_prim  = '0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic clear_log();
        got.delete(); got_cyc.delete(); got_gap.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 0);
        chk(out_data == '0, "R10 reset out_data", 64'(out_data), 0);
        chk(!fifo_ovf && !loc_ovf, "R10 reset flags", {62'd0, fifo_ovf, loc_ovf}, 0);
    endtask

    task automatic t_single();
        logic [63:0] p = 64'h1111_2222_3333_4444;
        int c4;
        clear_log();
        send_prim(p);
        c4 = cyc;
        in_idle();
        settle();
        chk(got.size() == 1, "R1 single count", 64'(got.size()), 1);
        if (got.size() > 0) begin
            chk(got[0] == p, "R1 word order", got[0], p);
            chk(got_cyc[0] == c4 + 3, "R11 forward latency", 64'(got_cyc[0] - c4), 3);
        end
    endtask

    task automatic t_order();
        logic [63:0] p[3] = '{64'hA000_A001_A002_A003, 64'hB000_B001_B002_B003, 64'hC000_C001_C002_C003};
        clear_log();
        for (int i = 0; i < 3; i++) send_prim(p[i]);
        in_idle();
        settle();
        chk(got.size() == 3, "R5 count", 64'(got.size()), 3);
        for (int i = 0; i < 3 && i < got.size(); i++) begin
            chk(got[i] == p[i], "R5 order", got[i], p[i]);
            if (i > 0) chk(got_gap[i] >= GAP, "R3 idle gap", 64'(got_gap[i]), GAP);
        end
    endtask

    task automatic t_partial();
        logic [63:0] p = 64'h5151_6262_7373_8484;
        clear_log();
        @(negedge clk); in_valid = 1'b1; in_data = 16'hDEAD;
        @(negedge clk); in_data = 16'hBEEF;
        in_idle();
        @(negedge clk); in_valid = 1'b1; in_data = 16'h0BAD;
        @(negedge clk); in_data = 16'hF00D;
        @(negedge clk); in_data = 16'hCAFE;
        in_idle();
        send_prim(p);
        in_idle();
        settle();
        chk(got.size() == 1, "R2 partial dropped", 64'(got.size()), 1);
        if (got.size() > 0) chk(got[0] == p, "R2 clean restart", got[0], p);
        chk(!fifo_ovf, "R2 no overflow", 64'(fifo_ovf), 0);
    endtask

    task automatic t_local_idle();
        logic [63:0] l = 64'h0123_4567_89AB_CDEF;
        int c0;
        clear_log();
        @(negedge clk);
        loc_valid = 1'b1; loc_prim = l;
        c0 = cyc;
        @(negedge clk);
        loc_valid = 1'b0; loc_prim = '0;
        settle();
        chk(got.size() == 1, "R7 local count", 64'(got.size()), 1);
        if (got.size() > 0) begin
            chk(got[0] == l, "R7 local content", got[0], l);
            chk(got_cyc[0] == c0 + 2, "R7 local latency", 64'(got_cyc[0] - c0), 2);
        end
    endtask

    task automatic t_priority();
        logic [63:0] a = 64'hAAAA_0001_0002_0003;
        logic [63:0] b = 64'hBBBB_0001_0002_0003;
        logic [63:0] l = 64'h1C1C_0001_0002_0003;
        clear_log();
        send_prim(a);
        send_prim(b);
        in_idle();
        put_local(l);
        settle();
        chk(got.size() == 3, "R6 count", 64'(got.size()), 3);
        if (got.size() == 3) begin
            chk(got[0] == a, "R6 first", got[0], a);
            chk(got[1] == b, "R6 forwarded before local", got[1], b);
            chk(got[2] == l, "R6 local last", got[2], l);
        end
        chk(!loc_ovf, "R9 no local drop", 64'(loc_ovf), 0);
    endtask

    task automatic t_local_ovf();
        logic [63:0] f[3] = '{64'hF1F1_0000_0000_0001, 64'hF2F2_0000_0000_0002, 64'hF3F3_0000_0000_0003};
        logic [63:0] l1 = 64'hE1E1_1111_1111_1111;
        logic [63:0] l2 = 64'hE2E2_2222_2222_2222;
        clear_log();
        for (int i = 0; i < 3; i++) send_prim(f[i]);
        in_idle();
        @(negedge clk); loc_valid = 1'b1; loc_prim = l1;
        @(negedge clk); loc_prim = l2;
        @(negedge clk); loc_valid = 1'b0; loc_prim = '0;
        chk(loc_ovf == 1'b1, "R9 loc_ovf set", 64'(loc_ovf), 1);
        settle();
        chk(got.size() == 4, "R9 count", 64'(got.size()), 4);
        if (got.size() == 4) chk(got[3] == l1, "R9 first local kept", got[3], l1);
        for (int i = 0; i < got.size(); i++)
            chk(got[i] != l2, "R9 second local dropped", got[i], l2);
        chk(loc_ovf == 1'b1, "R9 loc_ovf sticky", 64'(loc_ovf), 1);
        chk(!fifo_ovf, "R8 no fifo drop yet", 64'(fifo_ovf), 0);
    endtask

    task automatic t_fifo_ovf_and_reset();
        logic [63:0] s[16];
        int j = 0;
        bit inorder = 1'b1;
        clear_log();
        for (int i = 0; i < 16; i++) begin
            s[i] = {16'h9000 + 16'(i), 48'h0000_5555_AAAA};
            send_prim(s[i]);
        end
        in_idle();
        @(negedge clk);
        chk(fifo_ovf == 1'b1, "R8 fifo_ovf set", 64'(fifo_ovf), 1);
        settle();
        chk(fifo_ovf == 1'b1, "R8 fifo_ovf sticky", 64'(fifo_ovf), 1);
        chk(got.size() < 16, "R8 some dropped", 64'(got.size()), 15);
        if (got.size() > 0) chk(got[0] == s[0], "R8 head kept", got[0], s[0]);
        for (int i = 0; i < got.size(); i++) begin
            while (j < 16 && s[j] != got[i]) j++;
            if (j == 16) inorder = 1'b0;
            else j++;
        end
        chk(inorder, "R5 survivors in order", 64'(inorder), 1);
        // fill again, then reset while the queue still holds data
        clear_log();
        for (int i = 0; i < 6; i++) send_prim(s[i]);
        in_idle();
        do_reset();
        @(negedge clk);
        chk(!fifo_ovf && !loc_ovf, "R10 flags cleared", {62'd0, fifo_ovf, loc_ovf}, 0);
        clear_log();
        settle();
        chk(got.size() == 0, "R10 queue flushed", 64'(got.size()), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_order();
        t_partial();
        t_local_idle();
        t_priority();
        t_local_ovf();
        t_fifo_ovf_and_reset();
        chk(idle_bad == 0, "R4 zero when idle", 64'(idle_bad), 0);
        chk(run_bad == 0, "R3 four-word runs", 64'(run_bad), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule